// File: doc/BRIEF.md
# Three-Wire Configuration Write Port

This block receives configuration words from a host over three wires: a serial clock, a data line and a load-enable strobe. All three pins are sampled by the chip's system clock through a two-stage synchronizer, and rising edges are found on the synchronized levels. Each rising edge of the serial clock shifts one data bit into a 22-bit shift register, most significant bit first. A rising edge of load-enable then copies the upper 20 bits of that register into one of four configuration latches. The two lowest bits of the word pick the latch.

The four latches hold the settings for the IF reference divider, the IF feedback divider with its prescaler select, the RF reference divider and the RF feedback divider. The block keeps running no matter what the latched words say, so writes still land while the synthesizer sections are powered down. For each latch that is loaded, a one-cycle strobe is raised on that latch's bit. A sticky valid flag tells the divider logic that every latch has been loaded at least once since reset, and that the latched settings can now be used.

Top module: `cfg_serial_port`

## Requirements
- R1: Each synchronized rising edge of the serial clock shifts the data pin into the shift register at the least significant end, so a 22-bit word arrives most significant bit first.
- R2: On a synchronized rising edge of load-enable, shift-register bits [21:2] are copied into the latch chosen by bits [1:0]. Code 0 selects the IF reference latch, 1 the IF divider latch, 2 the RF reference latch and 3 the RF divider latch.
- R3: A load-enable edge leaves the three latches that were not selected unchanged.
- R4: For each load, `upd_stb_o` is high for exactly one system clock, with only bit [code] set. That is the same cycle in which the new latch value first shows at the outputs, three system clocks after the load-enable pin rises.
- R5: `cfg_valid_o` is low from reset until each of the four latches has been written at least once. After that it stays high until the next reset.
- R6: If fewer or more than 22 bits are shifted before load-enable rises, the latched word is the last 22 bits shifted in, and that includes bits left over from earlier words.
- R7: A synchronous active-high reset clears the shift register, all four latches, the strobes and the valid flag.
- R8: Holding load-enable high causes no further loads. Serial clock edges while load-enable is high still shift bits but change no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock pin, asynchronous |
| sdata_i | input | 1 | Serial data pin, asynchronous |
| sle_i | input | 1 | Load-enable pin, asynchronous |
| if_ref_o | output | 20 | IF reference latch contents |
| if_div_o | output | 20 | IF divider latch contents |
| rf_ref_o | output | 20 | RF reference latch contents |
| rf_div_o | output | 20 | RF divider latch contents |
| upd_stb_o | output | 4 | One-cycle strobe per latch loaded, bit index = select code |
| cfg_valid_o | output | 1 | All four latches written since reset |

## Verification
A shift register that is misaligned by one bit corrupts both the select code and the data. It shows up on the next load, three clocks after load-enable rises, as a strobe on the wrong bit and a wrong value on the wrong latch. A mask of written latches that is not kept correctly shows on `cfg_valid_o` as a flag that rises early or late on the fourth distinct load, or that falls again. A spurious edge from the synchronizer shows up as an extra strobe, or as a latch that changes while load-enable is held high.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

    localparam int WORD_W    = 22;
    localparam int SEL_W     = 2;
    localparam int DATA_W    = WORD_W - SEL_W;
    localparam int NUM_LATCH = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_IF_REF = 2'd0,
        SEL_IF_DIV = 2'd1,
        SEL_RF_REF = 2'd2,
        SEL_RF_DIV = 2'd3
    } latch_sel_e;

    typedef logic [DATA_W-1:0] cfg_word_t;

    // Payload in the upper bits, destination code in the trailing bits.
    typedef struct packed {
        cfg_word_t  data;
        latch_sel_e sel;
    } frame_t;

    function automatic logic [NUM_LATCH-1:0] sel_decode(input latch_sel_e s);
        logic [NUM_LATCH-1:0] m;
        m = '0;
        m[s] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= '0;
        else     chain_q[0] <= pin_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain_q[g] <= '0;
            else     chain_q[g] <= chain_q[g-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg
    import cfg_serial_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   shift_en,
    input  logic   bit_in,
    output frame_t word_o
);
    frame_t sh_q;

    always_ff @(posedge clk) begin
        if (rst)           sh_q <= '0;
        else if (shift_en) sh_q <= frame_t'({sh_q[WORD_W-2:0], bit_in});
    end

    assign word_o = sh_q;

    // R1
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
    import cfg_serial_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  frame_t               word_i,
    output cfg_word_t            latch_o [NUM_LATCH],
    output logic [NUM_LATCH-1:0] strobe_o,
    output logic                 all_written_o
);
    logic [NUM_LATCH-1:0] hit;
    logic [NUM_LATCH-1:0] written_q;

    assign hit = load_en ? sel_decode(word_i.sel) : '0;

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)         latch_o[i] <= '0;
            else if (hit[i]) latch_o[i] <= word_i.data;
        end

        // R3
        untouched_stable_chk: assert property (@(posedge clk) disable iff (rst)
            !strobe_o[i] |-> $stable(latch_o[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_o  <= '0;
            written_q <= '0;
        end else begin
            strobe_o  <= hit;
            written_q <= written_q | hit;
        end
    end

    assign all_written_o = &written_q;

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

    // R5
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        all_written_o |=> all_written_o);

    // R5
    valid_rise_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(all_written_o) |-> (strobe_o != '0));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sclk_i,
    input  logic                 sdata_i,
    input  logic                 sle_i,
    output logic [DATA_W-1:0]    if_ref_o,
    output logic [DATA_W-1:0]    if_div_o,
    output logic [DATA_W-1:0]    rf_ref_o,
    output logic [DATA_W-1:0]    rf_div_o,
    output logic [NUM_LATCH-1:0] upd_stb_o,
    output logic                 cfg_valid_o
);
    localparam int PIN_W = 3;

    logic [PIN_W-1:0] pin_lvl;
    logic             sclk_prev_q, le_prev_q;
    logic             sclk_rise, le_rise;
    frame_t           frame;
    cfg_word_t        latches [NUM_LATCH];

    pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .pin_i   ({sle_i, sdata_i, sclk_i}),
        .level_o (pin_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= 1'b0;
            le_prev_q   <= 1'b0;
        end else begin
            sclk_prev_q <= pin_lvl[0];
            le_prev_q   <= pin_lvl[2];
        end
    end

    assign sclk_rise = pin_lvl[0] & ~sclk_prev_q;
    assign le_rise   = pin_lvl[2] & ~le_prev_q;

    cfg_shift_reg shreg_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (sclk_rise),
        .bit_in   (pin_lvl[1]),
        .word_o   (frame)
    );

    cfg_latch_bank bank_i (
        .clk           (clk),
        .rst           (rst),
        .load_en       (le_rise),
        .word_i        (frame),
        .latch_o       (latches),
        .strobe_o      (upd_stb_o),
        .all_written_o (cfg_valid_o)
    );

    assign if_ref_o = latches[SEL_IF_REF];
    assign if_div_o = latches[SEL_IF_DIV];
    assign rf_ref_o = latches[SEL_RF_REF];
    assign rf_div_o = latches[SEL_RF_DIV];

    // R8
    le_single_edge_chk: assert property (@(posedge clk) disable iff (rst)
        le_rise |=> !le_rise);

    // R8
    sclk_single_edge_chk: assert property (@(posedge clk) disable iff (rst)
        sclk_rise |=> !sclk_rise);
endmodule

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
    logic [19:0] if_ref, if_div, rf_ref, rf_div;
    logic [3:0]  upd_stb;
    logic        cfg_valid;

    int n_chk = 0, n_fail = 0;
    logic [21:0] model_sr = '0;
    logic [19:0] exp_l [4];
    logic [3:0]  exp_written = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_port dut_i (
        .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
        .if_ref_o(if_ref), .if_div_o(if_div), .rf_ref_o(rf_ref), .rf_div_o(rf_div),
        .upd_stb_o(upd_stb), .cfg_valid_o(cfg_valid)
    );

    function automatic logic [19:0] get_latch(input int i);
        case (i)
            0: return if_ref;
            1: return if_div;
            2: return rf_ref;
            default: return rf_div;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all_latches(input string req);
        for (int i = 0; i < 4; i++) check(req, get_latch(i), exp_l[i]);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); sclk = 1'b0; sdata = b;
        @(negedge clk); sclk = 1'b1;
        repeat (3) @(negedge clk);
        model_sr = {model_sr[20:0], b};
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
        @(negedge clk); sclk = 1'b0;
    endtask

    // Raise load-enable, sample when the load becomes visible, then drop it.
    task automatic load(input string req);
        int code;
        code = int'(model_sr[1:0]);
        @(negedge clk); sle = 1'b1;
        repeat (3) @(negedge clk);
        exp_l[code] = model_sr[21:2];
        exp_written[code] = 1'b1;
        check({req, " R4 strobe"}, upd_stb, 32'(4'b1 << code));
        check({req, " R2 latch"}, get_latch(code), exp_l[code]);
        check_all_latches({req, " R3 others"});
        check({req, " R5 valid"}, cfg_valid, (&exp_written) ? 1 : 0);
        @(negedge clk);
        check({req, " R4 strobe width"}, upd_stb, 0);
        sle = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic write_word(input logic [19:0] d, input logic [1:0] c, input string req);
        send_bits({10'd0, d, c}, 22);
        load(req);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_l[i] = '0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R7 reset state
        check_all_latches("R7 reset latches");
        check("R7 reset strobe", upd_stb, 0);
        check("R7 reset valid", cfg_valid, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 R2 directed: each code, valid only after the fourth distinct latch
        write_word(20'hA5A5A, 2'd2, "R1 rf_ref");
        write_word(20'h12345, 2'd0, "R1 if_ref");
        write_word(20'hFFFFF, 2'd0, "R2 rewrite if_ref");
        write_word(20'h00001, 2'd3, "R2 rf_div");
        check("R5 not yet valid", cfg_valid, 0);
        write_word(20'h80000, 2'd1, "R2 if_div");
        check("R5 valid after four", cfg_valid, 1);

        // R6 short word: 10 bits after a full one keeps the 12 older bits
        send_bits(32'h2A7, 10);
        load("R6 short");
        // R6 long word: 30 bits, only the last 22 count
        send_bits(32'h3ABCDEF1, 30);
        load("R6 long");

        // R8 le held high: more sclk edges, no new load
        @(negedge clk); sle = 1'b1;
        repeat (4) @(negedge clk);
        exp_l[int'(model_sr[1:0])] = model_sr[21:2];
        send_bits(32'h5, 6);
        check("R8 no strobe while held", upd_stb, 0);
        check_all_latches("R8 latches held");
        @(negedge clk); sle = 1'b0;
        repeat (3) @(negedge clk);

        // random words
        for (int t = 0; t < 24; t++) begin
            logic [31:0] r;
            r = $urandom;
            write_word(r[19:0], r[21:20], "R2 random");
        end
        check("R5 stays valid", cfg_valid, 1);

        // R7 reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 4; i++) exp_l[i] = '0;
        exp_written = '0;
        model_sr = '0;
        @(negedge clk);
        check("R7 reset valid again", cfg_valid, 0);
        check_all_latches("R7 reset latches again");
        write_word(20'h0BEEF, 2'd3, "R5 after reset");
        check("R5 one latch not valid", cfg_valid, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule